// File: doc/BRIEF.md
# Polled Memory-Mapped I/O Port

This block places a small set of device registers in a reserved window at the top of a processor's address space. There is no memory behind this window. The processor reaches the registers with ordinary loads and stores. One receive channel brings bytes in from an input device, and one transmit channel sends bytes out to an output device.

Each channel has a ready flag and an interrupt-enable bit in its control word, and a one-byte data register. The device raises the ready flag when a byte has arrived or when it can take another byte. The processor's data access drops the flag again. That side effect is the handshake between a slow device and a fast processor. Software can poll the flag. It can also enable a level interrupt request, which stays asserted while any enabled channel is ready.

Top module: `mmio_poll_port`

## Requirements
- R1: Only addresses with bits 31:16 equal to 0xFFFF and bits 15:4 equal to zero select a register. A load anywhere else, inside or outside the window, returns 0, and a store there changes nothing.
- R2: Address bits 3:2 select the register: 0 receive control, 1 receive data, 2 transmit control, 3 transmit data. A control word carries ready in bit 0 and interrupt enable in bit 1, with all other bits zero. A data word carries the byte in bits 7:0, with all other bits zero. A load's result appears on bus_rdata in the cycle after the load and holds until the next load.
- R3: A cycle with rx_dev_valid high captures rx_dev_byte into the receive data register and sets receive ready.
- R4: A load from receive data while receive ready is 1 returns the held byte and clears receive ready.
- R5: A load from receive data while receive ready is 0 returns the last captured byte and leaves ready at 0.
- R6: A store to transmit data while transmit ready is 1 captures wdata bits 7:0 onto tx_dev_byte and clears transmit ready. It also pulses tx_dev_strobe for exactly the following cycle. A tx_dev_done cycle sets transmit ready.
- R7: A store to transmit data while transmit ready is 0 is ignored: there is no strobe, tx_dev_byte is unchanged and ready stays 0.
- R8: When a device set and a clearing processor access fall in the same cycle, ready ends at 1. The access itself still completes: the receive load returns the old byte and the new byte is captured, and the transmit store is accepted and strobed.
- R9: Loads from control registers have no side effects. A store to a control register writes only the interrupt enable from wdata bit 1; wdata bit 0 and stores to receive data are ignored.
- R10: irq is high exactly while (receive ready AND receive enable) OR (transmit ready AND transmit enable).
- R11: After synchronous reset, receive ready is 0, transmit ready is 1, both enables are 0, and bus_rdata and tx_dev_byte are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_valid | input | 1 | Bus access this cycle |
| bus_write | input | 1 | 1 for store, 0 for load |
| bus_addr | input | 32 | Byte address of the access |
| bus_wdata | input | 32 | Store data |
| bus_rdata | output | 32 | Load result, registered |
| rx_dev_valid | input | 1 | Input device presents a byte |
| rx_dev_byte | input | 8 | Byte from input device |
| tx_dev_byte | output | 8 | Last accepted output byte |
| tx_dev_strobe | output | 1 | One-cycle pulse for a newly accepted output byte |
| tx_dev_done | input | 1 | Output device can take another byte |
| irq | output | 1 | Level interrupt request |

## Verification
The assertions check several behaviours on every cycle:
- a device set is never lost against a clearing access;
- an accepted data access drops ready;
- a data access while not ready leaves the byte untouched;
- control loads and out-of-window accesses leave both flags as they were;
- each channel comes out of reset with the right values.

Only the bench's scenarios can show that the bytes travel correctly end to end. They also show the word layout of every register, the decode of every offset in the window, and the interrupt level for each combination of enables and flags. Both the full byte sweeps and the same-cycle collision cases are left to those scenarios.

// File: rtl/mmio_pkg.sv
package mmio_pkg;
    typedef enum logic [1:0] {
        SEL_RX_CTRL = 2'd0,
        SEL_RX_DATA = 2'd1,
        SEL_TX_CTRL = 2'd2,
        SEL_TX_DATA = 2'd3
    } reg_sel_e;

    localparam int RDY_POS = 0;
    localparam int IEN_POS = 1;
    localparam int SEL_LO  = 2;
    localparam int SEL_HI  = 3;
endpackage

// File: rtl/mmio_addr_decode.sv
module mmio_addr_decode
    import mmio_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int REGION_BITS = 16,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 32'hFFFF_0000
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output reg_sel_e          sel
);
    localparam int OFS_TOP = SEL_HI + 1;

    logic window_hit;
    logic offset_hit;
    logic unused_low_bits;

    always_comb begin
        window_hit = (addr[ADDR_W-1:REGION_BITS] == BASE_ADDR[ADDR_W-1:REGION_BITS]);
        offset_hit = (addr[REGION_BITS-1:OFS_TOP] == '0);
        hit        = window_hit && offset_hit;
        sel        = reg_sel_e'(addr[SEL_HI:SEL_LO]);
    end

    assign unused_low_bits = ^addr[SEL_LO-1:0];
endmodule

// File: rtl/mmio_channel.sv
module mmio_channel
    import mmio_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter bit IS_TX  = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ctrl_wr,
    input  logic              ien_in,
    input  logic              data_acc,
    input  logic [BYTE_W-1:0] bus_byte,
    input  logic              dev_set,
    input  logic [BYTE_W-1:0] dev_byte,
    output logic              ready,
    output logic              ien,
    output logic [BYTE_W-1:0] data,
    output logic              taken
);
    typedef struct packed {
        logic              ready;
        logic              ien;
        logic [BYTE_W-1:0] data;
        logic              taken;
    } chan_t;

    chan_t st_d, st_q;
    logic  accept;
    logic  load_byte;
    logic [BYTE_W-1:0] new_byte;

    always_comb begin
        accept    = data_acc && st_q.ready;
        load_byte = IS_TX ? accept : dev_set;
        new_byte  = IS_TX ? bus_byte : dev_byte;

        st_d       = st_q;
        st_d.taken = accept;
        if (ctrl_wr) begin
            st_d.ien = ien_in;
        end
        if (accept) begin
            st_d.ready = 1'b0;
        end
        if (load_byte) begin
            st_d.data = new_byte;
        end
        if (dev_set) begin
            st_d.ready = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.ready <= IS_TX;
            st_q.ien   <= 1'b0;
            st_q.data  <= '0;
            st_q.taken <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ready = st_q.ready;
    assign ien   = st_q.ien;
    assign data  = st_q.data;
    assign taken = st_q.taken;

    assert_set_wins_R8: assert property (@(posedge clk) disable iff (rst)
        dev_set |=> ready);

    assert_accept_clears_R4: assert property (@(posedge clk) disable iff (rst)
        (data_acc && ready && !dev_set) |=> (!ready && taken));

    assert_idle_access_R7: assert property (@(posedge clk) disable iff (rst)
        (data_acc && !ready && !dev_set) |=> (!ready && !taken && $stable(data)));

    assert_reset_state_R11: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (ready == IS_TX && !ien && data == '0));
endmodule

// File: rtl/mmio_poll_port.sv
module mmio_poll_port
    import mmio_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int DATA_W      = 32,
    parameter int BYTE_W      = 8,
    parameter int REGION_BITS = 16,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 32'hFFFF_0000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              rx_dev_valid,
    input  logic [BYTE_W-1:0] rx_dev_byte,
    output logic [BYTE_W-1:0] tx_dev_byte,
    output logic              tx_dev_strobe,
    input  logic              tx_dev_done,
    output logic              irq
);
    localparam int PAD_W = DATA_W - BYTE_W;

    typedef struct packed {
        logic [DATA_W-1:0] rdata;
    } top_t;

    top_t     tp_d, tp_q;
    logic     hit;
    reg_sel_e sel;
    logic     is_load, is_store;
    logic     rx_ctrl_wr, rx_acc, tx_ctrl_wr, tx_acc;
    logic     rx_ready, rx_ien, rx_taken;
    logic     tx_ready, tx_ien;
    logic [BYTE_W-1:0] rx_data;
    logic [DATA_W-1:0] rd_val;
    logic     unused_wdata;

    mmio_addr_decode #(
        .ADDR_W      (ADDR_W),
        .REGION_BITS (REGION_BITS),
        .BASE_ADDR   (BASE_ADDR)
    ) u_dec (
        .addr (bus_addr),
        .hit  (hit),
        .sel  (sel)
    );

    always_comb begin
        is_load    = bus_valid && !bus_write && hit;
        is_store   = bus_valid &&  bus_write && hit;
        rx_ctrl_wr = is_store && (sel == SEL_RX_CTRL);
        tx_ctrl_wr = is_store && (sel == SEL_TX_CTRL);
        rx_acc     = is_load  && (sel == SEL_RX_DATA);
        tx_acc     = is_store && (sel == SEL_TX_DATA);
    end

    mmio_channel #(.BYTE_W(BYTE_W), .IS_TX(1'b0)) u_rx (
        .clk      (clk),
        .rst      (rst),
        .ctrl_wr  (rx_ctrl_wr),
        .ien_in   (bus_wdata[IEN_POS]),
        .data_acc (rx_acc),
        .bus_byte (bus_wdata[BYTE_W-1:0]),
        .dev_set  (rx_dev_valid),
        .dev_byte (rx_dev_byte),
        .ready    (rx_ready),
        .ien      (rx_ien),
        .data     (rx_data),
        .taken    (rx_taken)
    );

    mmio_channel #(.BYTE_W(BYTE_W), .IS_TX(1'b1)) u_tx (
        .clk      (clk),
        .rst      (rst),
        .ctrl_wr  (tx_ctrl_wr),
        .ien_in   (bus_wdata[IEN_POS]),
        .data_acc (tx_acc),
        .bus_byte (bus_wdata[BYTE_W-1:0]),
        .dev_set  (tx_dev_done),
        .dev_byte (rx_dev_byte),
        .ready    (tx_ready),
        .ien      (tx_ien),
        .data     (tx_dev_byte),
        .taken    (tx_dev_strobe)
    );

    always_comb begin
        rd_val = '0;
        unique case (sel)
            SEL_RX_CTRL: begin
                rd_val[RDY_POS] = rx_ready;
                rd_val[IEN_POS] = rx_ien;
            end
            SEL_RX_DATA: rd_val = {{PAD_W{1'b0}}, rx_data};
            SEL_TX_CTRL: begin
                rd_val[RDY_POS] = tx_ready;
                rd_val[IEN_POS] = tx_ien;
            end
            SEL_TX_DATA: rd_val = {{PAD_W{1'b0}}, tx_dev_byte};
            default:     rd_val = '0;
        endcase

        tp_d = tp_q;
        if (bus_valid && !bus_write) begin
            tp_d.rdata = hit ? rd_val : '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tp_q.rdata <= '0;
        end else begin
            tp_q <= tp_d;
        end
    end

    assign bus_rdata    = tp_q.rdata;
    assign irq          = (rx_ready && rx_ien) || (tx_ready && tx_ien);
    assign unused_wdata = ^{bus_wdata[DATA_W-1:BYTE_W], bus_wdata[RDY_POS]};

    assert_ctrl_load_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        (is_load && (sel == SEL_RX_CTRL || sel == SEL_TX_CTRL) && !rx_dev_valid && !tx_dev_done)
        |=> ($stable(rx_ready) && $stable(tx_ready) && !tx_dev_strobe));

    assert_outside_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && !hit && !rx_dev_valid && !tx_dev_done)
        |=> ($stable(rx_ready) && $stable(tx_ready) && $stable(rx_ien) && $stable(tx_ien)
             && !tx_dev_strobe && (!$past(bus_write) -> bus_rdata == '0)));

    assert_rx_taken_R4: assert property (@(posedge clk) disable iff (rst)
        rx_taken |-> (!rx_ready || $past(rx_dev_valid)));
endmodule

// File: tb/mmio_poll_port_test.sv
module mmio_poll_port_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [31:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        rx_dev_valid = 1'b0;
    logic [7:0]  rx_dev_byte = '0;
    logic [7:0]  tx_dev_byte;
    logic        tx_dev_strobe;
    logic        tx_dev_done = 1'b0;
    logic        irq;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    logic       m_rx_rdy = 1'b0, m_rx_ie = 1'b0, m_tx_rdy = 1'b1, m_tx_ie = 1'b0;
    logic [7:0] m_rx_byte = '0, m_tx_byte = '0;
    logic [31:0] m_rdata = '0;
    logic       m_strobe = 1'b0;

    localparam logic [31:0] BASE = 32'hFFFF_0000;

    always #2 clk = ~clk;

    mmio_poll_port uut (
        .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rx_dev_valid(rx_dev_valid), .rx_dev_byte(rx_dev_byte),
        .tx_dev_byte(tx_dev_byte), .tx_dev_strobe(tx_dev_strobe),
        .tx_dev_done(tx_dev_done), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mread(input logic [1:0] s);
        case (s)
            2'd0:    return {30'b0, m_rx_ie, m_rx_rdy};
            2'd1:    return {24'b0, m_rx_byte};
            2'd2:    return {30'b0, m_tx_ie, m_tx_rdy};
            default: return {24'b0, m_tx_byte};
        endcase
    endfunction

    task automatic step(input logic v, input logic w, input logic [31:0] a,
                        input logic [31:0] wd, input logic rv, input logic [7:0] rb,
                        input logic dn, input string tag);
        logic       hit;
        logic [1:0] s;
        logic       rx_clear, tx_accept;
        @(negedge clk);
        bus_valid = v; bus_write = w; bus_addr = a; bus_wdata = wd;
        rx_dev_valid = rv; rx_dev_byte = rb; tx_dev_done = dn;
        hit = (a[31:16] == 16'hFFFF) && (a[15:4] == 12'h000);
        s = a[3:2];
        m_strobe = 1'b0;
        if (v && !w) m_rdata = hit ? mread(s) : 32'h0;
        rx_clear  = v && !w && hit && s == 2'd1 && m_rx_rdy;
        tx_accept = v &&  w && hit && s == 2'd3 && m_tx_rdy;
        if (rx_clear) m_rx_rdy = 1'b0;
        if (rv) begin m_rx_rdy = 1'b1; m_rx_byte = rb; end
        if (tx_accept) begin m_tx_rdy = 1'b0; m_tx_byte = wd[7:0]; m_strobe = 1'b1; end
        if (dn) m_tx_rdy = 1'b1;
        if (v && w && hit && s == 2'd0) m_rx_ie = wd[1];
        if (v && w && hit && s == 2'd2) m_tx_ie = wd[1];
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0; rx_dev_valid = 1'b0; tx_dev_done = 1'b0;
        chk({tag, " rdata"},  bus_rdata, m_rdata);
        chk({tag, " strobe"}, {31'b0, tx_dev_strobe}, {31'b0, m_strobe});
        chk({tag, " txbyte"}, {24'b0, tx_dev_byte}, {24'b0, m_tx_byte});
        chk({tag, " irq"},    {31'b0, irq}, {31'b0, (m_rx_rdy & m_rx_ie) | (m_tx_rdy & m_tx_ie)});
    endtask

    task automatic ld(input logic [31:0] a, input string tag);
        step(1'b1, 1'b0, a, 32'h0, 1'b0, 8'h00, 1'b0, tag);
    endtask

    task automatic st(input logic [31:0] a, input logic [31:0] wd, input string tag);
        step(1'b1, 1'b1, a, wd, 1'b0, 8'h00, 1'b0, tag);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk("R11 rdata after reset", bus_rdata, 32'h0);
        chk("R11 txbyte after reset", {24'b0, tx_dev_byte}, 32'h0);
        chk("R11 irq after reset", {31'b0, irq}, 32'h0);
        ld(BASE + 32'h0, "R11 rx ctrl");
        ld(BASE + 32'h8, "R11 tx ctrl");

        for (int b = 0; b < 256; b++) begin
            step(1'b0, 1'b0, 32'h0, 32'h0, 1'b1, 8'(b), 1'b0, "R3 device push");
            ld(BASE + 32'h0, "R3 rx ready set");
            ld(BASE + 32'h4, "R4 rx data load");
            ld(BASE + 32'h0, "R4 rx ready cleared");
        end
        ld(BASE + 32'h4, "R5 empty rx load");
        ld(BASE + 32'h0, "R5 rx flag stays 0");

        for (int b = 0; b < 256; b++) begin
            st(BASE + 32'hC, {8'(b ^ 8'h5A), 8'(~b), 8'(b * 3), 8'(b)}, "R6 tx store");
            ld(BASE + 32'h8, "R6 tx ready cleared");
            st(BASE + 32'hC, {24'hABCDEF, 8'(b ^ 8'hFF)}, "R7 blocked tx store");
            ld(BASE + 32'hC, "R7 tx byte kept");
            step(1'b0, 1'b0, 32'h0, 32'h0, 1'b0, 8'h00, 1'b1, "R6 device done");
            ld(BASE + 32'h8, "R6 tx ready set");
        end

        st(BASE + 32'h0, 32'h1, "R9 bit0 store");
        ld(BASE + 32'h0, "R9 rx ctrl after bit0 store");
        st(BASE + 32'h8, 32'hFFFF_FFFD, "R9 tx ctrl store ien0");
        ld(BASE + 32'h8, "R9 tx ctrl readback");
        step(1'b0, 1'b0, 32'h0, 32'h0, 1'b1, 8'hC3, 1'b0, "R9 push");
        st(BASE + 32'h4, 32'h0000_0011, "R9 rx data store ignored");
        ld(BASE + 32'h0, "R9 rx ready still set");
        ld(BASE + 32'h0, "R9 repeat ctrl load");
        ld(BASE + 32'h4, "R9 rx byte unchanged");

        for (int c = 0; c < 16; c++) begin
            st(BASE + 32'h0, {30'b0, c[0], 1'b0}, "R10 rx ien");
            st(BASE + 32'h8, {30'b0, c[1], 1'b0}, "R10 tx ien");
            if (c[2]) step(1'b0, 1'b0, 32'h0, 32'h0, 1'b1, 8'(c), 1'b0, "R10 rx ready on");
            else      ld(BASE + 32'h4, "R10 rx ready off");
            if (c[3]) step(1'b0, 1'b0, 32'h0, 32'h0, 1'b0, 8'h00, 1'b1, "R10 tx ready on");
            else      st(BASE + 32'hC, 32'h0000_0042 + 32'(c), "R10 tx ready off");
            ld(BASE + 32'h0, "R10 rx ctrl");
        end
        st(BASE + 32'h0, 32'h0, "R10 ien off");
        st(BASE + 32'h8, 32'h0, "R10 ien off");

        step(1'b0, 1'b0, 32'h0, 32'h0, 1'b1, 8'h11, 1'b0, "R8 rx prime");
        step(1'b1, 1'b0, BASE + 32'h4, 32'h0, 1'b1, 8'h22, 1'b0, "R8 rx collide");
        ld(BASE + 32'h0, "R8 rx ready kept");
        ld(BASE + 32'h4, "R8 rx new byte");
        step(1'b0, 1'b0, 32'h0, 32'h0, 1'b0, 8'h00, 1'b1, "R8 tx prime");
        step(1'b1, 1'b1, BASE + 32'hC, 32'h0000_0077, 1'b0, 8'h00, 1'b1, "R8 tx collide");
        ld(BASE + 32'h8, "R8 tx ready kept");
        st(BASE + 32'hC, 32'h0000_0088, "R8 tx accepted after collide");

        step(1'b0, 1'b0, 32'h0, 32'h0, 1'b1, 8'h5C, 1'b0, "R2 rx push");
        for (int o = 0; o < 64; o += 4) begin
            ld(BASE + 32'(o), (o < 16) ? "R2 map offset" : "R1 unused window offset");
        end
        ld(32'hFFFE_0000, "R1 below window");
        ld(32'h0000_0000, "R1 low memory");
        ld(32'hFFFF_0100, "R1 high offset");
        st(32'hFFFE_0000, 32'h2, "R1 outside ctrl store");
        st(32'hFFFF_0108, 32'h2, "R1 outside tx ctrl store");
        step(1'b1, 1'b0, 32'h7FFF_0004, 32'h0, 1'b0, 8'h00, 1'b0, "R1 outside rx load");
        ld(BASE + 32'h0, "R1 rx ctrl unchanged");
        ld(BASE + 32'h8, "R1 tx ctrl unchanged");
        ld(BASE + 32'h4, "R2 rx data");
        ld(BASE + 32'h3, "R2 low addr bits ignored");

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule